// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter. It produces a one-cycle system-reset pulse if software does not restart its count period in time. The counter advances once per bus-clock cycle in which the watchdog clock source delivers an enable. It overflows after its all-ones value, and on that overflow it raises the reset pulse.

Software reaches the block through a small register write port and a combinational read port. The control register can only be changed after the unlock key 0x0096 has been written to a separate protection register. Any other value written there locks it again. The control register holds three things:

- a 4-bit run code, where the single code 0xA means stop;
- a self-clearing bit that restarts the count period;
- a debug-run flag, which decides whether counting continues while the processor is halted in debug mode.

When counting is frozen, whether by debug mode or by the clock enable going low, the count and every register field are kept.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the protection register is locked (reads 0), the control register reads 0x000A (run code 0xA, debug-run 0), the count reads 0 and `sys_rst` is low.
- R2: A write of 0x0096 to address 0 unlocks the protection register (bit 0 of the address-0 read becomes 1). A write of any other value to address 0 locks it (reads 0).
- R3: A write to the control register (address 1) while locked is ignored. The control read-back and the count are unchanged.
- R4: While the run field (control bits [3:0]) holds 0xA, the count does not advance. With any other run code, the count rises by one on each clock edge at which `clk_en` is high.
- R5: An unlocked control write with bit 4 set clears the count to 0 at that edge. This takes priority over a tick in the same cycle, and no reset pulse results from that tick. Bit 4 always reads back as 0.
- R6: A tick while the count is at its all-ones value sets the count to 0. It also drives `sys_rst` high for exactly one clock, in the cycle after that edge.
- R7: With debug-run (control bit 8) at 0 and `dbg_mode` high, the count holds its value. Counting resumes from that value once `dbg_mode` falls.
- R8: With debug-run at 1, the count keeps advancing while `dbg_mode` is high.
- R9: While `clk_en` is low the count holds.
- R10: Reads are combinational: address 0 gives {15'b0, unlocked}; address 1 gives {7'b0, debug-run, 3'b0, 1'b0, run[3:0]}; address 2 gives the zero-extended count; address 3 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 protection, 1 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| clk_en | input | 1 | Tick enable from the watchdog clock source |
| dbg_mode | input | 1 | High while the processor is in debug mode |
| sys_rst | output | 1 | One-cycle system-reset request on overflow |

## Verification
The period-restart write and the overflow tick can land on the same clock edge. The bench provokes this by bringing the count to its all-ones value, then raising `clk_en` in the same cycle as a control write with the clear bit set. It judges the outcome by reading a count of 0 afterwards and counting no reset pulse. The bench then repeats the overflow without the clear write, where one pulse of one cycle and a wrapped count of 0 are expected.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int REG_W = 16;
  localparam logic [1:0] ADDR_PROT = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam int RUN_W        = 4;
  localparam int CTRL_CLR_BIT = 4;
  localparam int CTRL_DBG_BIT = 8;

  typedef struct packed {
    logic             dbg_run;
    logic [RUN_W-1:0] run;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
  parameter int          KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'h0096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_wr,
  input  logic [KEY_W-1:0] prot_data,
  output logic             unlocked
);
  logic unlocked_q, unlocked_d;

  always_comb begin
    unlocked_d = unlocked_q;
    if (prot_wr) unlocked_d = (prot_data == KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked_q <= 1'b0;
    else        unlocked_q <= unlocked_d;
  end

  assign unlocked = unlocked_q;

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && prot_data == KEY) |=> unlocked); // R2
  AST_BADKEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && prot_data != KEY) |=> !unlocked); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_wr |=> $stable(unlocked)); // R2
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_keyed_pkg::*;
#(
  parameter logic [RUN_W-1:0] STOP_CODE = 4'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             unlocked,
  input  logic [RUN_W-1:0] run_in,
  input  logic             clr_in,
  input  logic             dbg_in,
  output wdt_ctrl_t        ctrl,
  output logic             running,
  output logic             clr_req
);
  wdt_ctrl_t ctrl_q, ctrl_d;
  logic      wr_ok;

  assign wr_ok = ctrl_wr && unlocked;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) begin
      ctrl_d.run     = run_in;
      ctrl_d.dbg_run = dbg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.run     <= STOP_CODE;
      ctrl_q.dbg_run <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign running = (ctrl_q.run != STOP_CODE);
  assign clr_req = wr_ok && clr_in;

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlocked) |=> $stable(ctrl)); // R3
  AST_UNLOCKED_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && unlocked) |=> (ctrl.run == $past(run_in) && ctrl.dbg_run == $past(dbg_in))); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             clk_en,
  input  logic             dbg_mode,
  input  logic             dbg_run,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             sys_rst
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             frozen, advance;

  assign frozen  = dbg_mode && !dbg_run;
  assign advance = running && clk_en && !frozen;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr_req) begin
      cnt_d = '0;
    end else if (advance) begin
      if (cnt_q == CNT_MAX) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt     = cnt_q;
  assign sys_rst = pulse_q;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr_req) |=> $stable(cnt)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (cnt == '0 && !sys_rst)); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst); // R6
  AST_PULSE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> cnt == '0); // R6
  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !dbg_run && !clr_req) |=> $stable(cnt)); // R7
  AST_NO_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !clr_req) |=> $stable(cnt)); // R9
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter logic [REG_W-1:0] UNLOCK_KEY = 16'h0096,
  parameter logic [RUN_W-1:0] STOP_CODE = 4'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             clk_en,
  input  logic             dbg_mode,
  output logic             sys_rst
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             prot_wr, ctrl_wr, unlocked, running, clr_req;
  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] cnt_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign prot_wr = wr_en && (wr_addr == ADDR_PROT);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  wdt_keylock #(.KEY_W(REG_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .prot_wr(prot_wr),
    .prot_data(wr_data), .unlocked(unlocked)
  );

  wdt_ctrl_regs #(.STOP_CODE(STOP_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .ctrl_wr(ctrl_wr), .unlocked(unlocked),
    .run_in(wr_data[RUN_W-1:0]), .clr_in(wr_data[CTRL_CLR_BIT]),
    .dbg_in(wr_data[CTRL_DBG_BIT]), .ctrl(ctrl), .running(running),
    .clr_req(clr_req)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .running(running), .clk_en(clk_en),
    .dbg_mode(dbg_mode), .dbg_run(ctrl.dbg_run), .clr_req(clr_req),
    .cnt(cnt), .sys_rst(sys_rst)
  );

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_PROT: rd_data[0] = unlocked;
      ADDR_CTRL: begin
        rd_data[RUN_W-1:0]   = ctrl.run;
        rd_data[CTRL_DBG_BIT] = ctrl.dbg_run;
      end
      ADDR_CNT:  rd_data = cnt_ext;
      default:   rd_data = '0;
    endcase
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!unlocked && !sys_rst && cnt == '0)); // R1
endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
  localparam int CW  = 6;
  localparam int MOD = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, clk_en, dbg_mode;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        sys_rst;
  int total = 0, bad = 0, pulses = 0, exp_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_keyed #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .clk_en(clk_en), .dbg_mode(dbg_mode), .sys_rst(sys_rst)
  );

  always @(negedge clk) if (sys_rst === 1'b1) pulses++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic tick(input int n);
    clk_en = 1'b1;
    repeat (n) @(negedge clk);
    clk_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_reset_state();
    int v;
    rd(2'd0, v); check("R1 prot locked", v, 0);
    rd(2'd1, v); check("R1 ctrl reset", v, 16'h000A);
    rd(2'd2, v); check("R1 count zero", v, 0);
    check("R1 sys_rst low", int'(sys_rst), 0);
  endtask

  initial begin
    int v, p0, n;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; clk_en = 0; dbg_mode = 0;
    do_reset();
    check_reset_state();

    tick(5); rd(2'd2, v); check("R4 stopped at reset", v, 0);

    wr(2'd1, 16'h0003);
    rd(2'd1, v); check("R3 locked ctrl unchanged", v, 16'h000A);
    tick(3); rd(2'd2, v); check("R3 locked count unchanged", v, 0);

    wr(2'd0, 16'h0096); rd(2'd0, v); check("R2 unlock", v, 1);
    wr(2'd0, 16'h0097); rd(2'd0, v); check("R2 relock near key", v, 0);
    wr(2'd0, 16'h0096); rd(2'd0, v); check("R2 unlock again", v, 1);

    for (int code = 0; code < 16; code++) begin
      wr(2'd1, 16'h0010 | code[15:0]);
      rd(2'd1, v); check("R4 run code readback, R5 clear bit reads 0", v, code);
      rd(2'd2, v); check("R5 clear to zero", v, 0);
      n = 3 + code * 9;
      p0 = pulses;
      tick(n);
      rd(2'd2, v);
      check("R4 count after run", v, (code == 10) ? 0 : n % MOD);
      check("R6 overflow pulses", pulses - p0, (code == 10) ? 0 : n / MOD);
    end

    wr(2'd1, 16'h0015); exp_cnt = 0;
    wr(2'd0, 16'h0000); rd(2'd0, v); check("R2 lock by other value", v, 0);
    wr(2'd1, 16'h011A);
    rd(2'd1, v); check("R3 locked write ignored", v, 16'h0005);
    tick(4); exp_cnt = 4;
    rd(2'd2, v); check("R3 no clear while locked", v, exp_cnt);
    wr(2'd0, 16'h0096);

    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R9 clk_en low holds", v, exp_cnt);

    dbg_mode = 1'b1;
    tick(7);
    rd(2'd2, v); check("R7 debug freeze", v, exp_cnt);
    dbg_mode = 1'b0;
    tick(2); exp_cnt += 2;
    rd(2'd2, v); check("R7 resume after debug", v, exp_cnt);

    wr(2'd1, 16'h0105);
    rd(2'd1, v); check("R8 debug-run readback", v, 16'h0105);
    dbg_mode = 1'b1;
    tick(6); exp_cnt += 6;
    rd(2'd2, v); check("R8 counts in debug", v, exp_cnt);
    dbg_mode = 1'b0;

    wr(2'd1, 16'h0015);
    tick(MOD - 1);
    rd(2'd2, v); check("R6 at all-ones", v, MOD - 1);
    p0 = pulses;
    @(negedge clk);
    clk_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0015;
    @(negedge clk);
    clk_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rd(2'd2, v); check("R5 clear beats overflow tick", v, 0);
    check("R5 no pulse on collision", pulses - p0, 0);

    tick(MOD - 1);
    p0 = pulses;
    tick(1);
    rd(2'd2, v); check("R6 wrap to zero", v, 0);
    check("R6 one pulse", pulses - p0, 1);
    repeat (3) @(negedge clk);
    check("R6 pulse lasts one cycle", pulses - p0, 1);

    wr(2'd1, 16'h001A);
    tick(5);
    rd(2'd2, v); check("R4 stop code halts", v, 0);
    rd(2'd3, v); check("R10 unused address reads 0", v, 0);

    wr(2'd1, 16'h0017);
    tick(9);
    do_reset();
    check_reset_state();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule